// File: doc/BRIEF.md
# Sub-Word Write Read-Modify-Write ECC Controller

This controller is placed between a requester and a 64-bit single-port SRAM. Each SRAM row holds one data word together with its SECDED check bits, 72 bits in all, and a row can only be written whole. Requests use a small valid/ready interface that carries a write flag, a word address, eight byte-lane enables and 64 bits of write data. A write with every lane enabled is encoded and stored at once. Any narrower write (byte, halfword or word) reads the stored row, corrects it, replaces the enabled lanes, recomputes the check bits over the full word and writes the row back. While this runs, the request side is stalled.

Reads return decoded data through a one-cycle response pulse. A single-bit fault is corrected and reported on a correctable-error pulse. A double-bit fault produces an error response and a pulse on the alarm output. The alarm also fires when the read phase of a merge finds a fault it cannot repair.

An integrity-enable input selects between two modes. With it low, stored words are used raw and no error is ever flagged. Narrow writes still produce valid check bits in this mode, so memory full of garbage can be initialised lane by lane.

Top module: `rmw_ecc_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `req_ready` is 1 and `rsp_valid`, `corr_err`, `ecc_alarm` and `mem_en` are 0.
- R2: A write with `req_be` = 8'hFF issues exactly one SRAM write in the cycle after acceptance, with no SRAM read, and `req_ready` stays high.
- R3: A write with any other `req_be` value reads the SRAM row in the cycle after acceptance. It writes the row back two cycles later. `req_ready` is low for the three cycles after acceptance. Bit lane k of `req_be` selects data bits 8k+7..8k. A later read returns the new bytes in the enabled lanes and the old bytes in all other lanes.
- R4: A read drives `rsp_valid` high for exactly one cycle, two cycles after the acceptance edge. `rsp_rdata` carries the stored word at that time.
- R5: With `ecc_en` = 1, a stored row that has one flipped bit (any of the 72) reads back as the correct data. `rsp_err` = 0, and `corr_err` pulses together with `rsp_valid`.
- R6: With `ecc_en` = 1, a stored row that has two flipped bits reads back with `rsp_err` = 1, and `ecc_alarm` pulses together with `rsp_valid`.
- R7: With `ecc_en` = 1, a narrow write to a row that has two flipped bits pulses `ecc_alarm` two cycles after acceptance and produces no response.
- R8: With `ecc_en` = 0, no read and no merge ever raises `corr_err`, `ecc_alarm` or `rsp_err`, even when the stored row is corrupted.
- R9: Narrow writes made with `ecc_en` = 0 that together cover all eight lanes leave a row that later reads back correctly with `ecc_en` = 1 and raises no flag, whatever the row held before.
- R10: With `ecc_en` = 1, a narrow write to a row that has one flipped bit merges into the corrected word. It pulses `corr_err` two cycles after acceptance, and the row written back is clean.
- R11: `corr_err` and `ecc_alarm` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ecc_en | input | 1 | 1 = check and correct stored words, 0 = use raw words |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_be | input | 8 | Byte-lane enables for writes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Read data was uncorrectable |
| corr_err | output | 1 | Correctable error seen, one-cycle pulse |
| ecc_alarm | output | 1 | Uncorrectable error seen, one-cycle pulse |
| mem_en | output | 1 | SRAM access strobe |
| mem_we | output | 1 | SRAM write when 1, read when 0 |
| mem_addr | output | AW | SRAM row address |
| mem_wdata | output | 72 | SRAM row write data (data and check bits) |
| mem_rdata | input | 72 | SRAM row read data, valid one cycle after a read strobe |

## Verification
Take the acceptance edge as edge 0. SRAM strobes appear after edge 0. Read responses and the merge error flags are due after edge 2. `req_ready` comes back high after edge 3 for a merge and stays high for a full write. The bench drives each request on a falling edge and then waits a fixed number of falling edges before sampling. It checks that `rsp_valid` is still low one falling edge early, so a result that arrives one cycle late or early is reported. Faults are injected by flipping bits in the bench's SRAM model, so the expected read results do not depend on the code layout.

// File: rtl/rmw_ecc_pkg.sv
package rmw_ecc_pkg;
  localparam int DATA_W  = 64;
  localparam int CODE_W  = 72;
  localparam int LANES   = DATA_W / 8;
  localparam int SYN_W   = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_MERGE, ST_WRITE} rmw_state_t;

  function automatic logic is_pow2(input int pos);
    return (pos & (pos - 1)) == 0;
  endfunction

  // Hamming positions 1..71 with parity at powers of two, overall parity in bit 0
  function automatic logic [CODE_W-1:0] code_word(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] cw;
    int j;
    cw = '0;
    j = 0;
    for (int i = 1; i < CODE_W; i++) begin
      if (!is_pow2(i)) begin
        cw[i] = d[j];
        j++;
      end
    end
    for (int k = 0; k < SYN_W; k++) begin
      logic p;
      p = 1'b0;
      for (int i = 1; i < CODE_W; i++)
        if (((i >> k) & 1) == 1 && !is_pow2(i)) p ^= cw[i];
      cw[1 << k] = p;
    end
    cw[0] = ^cw[CODE_W-1:1];
    return cw;
  endfunction

  function automatic logic [DATA_W-1:0] code_data(input logic [CODE_W-1:0] cw);
    logic [DATA_W-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int i = 1; i < CODE_W; i++) begin
      if (!is_pow2(i)) begin
        d[j] = cw[i];
        j++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import rmw_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_in,
  output logic [CODE_W-1:0] code_out
);
  always_comb code_out = code_word(data_in);
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import rmw_ecc_pkg::*;
(
  input  logic [CODE_W-1:0] code_in,
  output logic [DATA_W-1:0] raw_data,
  output logic [DATA_W-1:0] fixed_data,
  output logic              single_err,
  output logic              double_err
);
  logic [SYN_W-1:0]  syn;
  logic              par;
  logic [CODE_W-1:0] repaired;

  always_comb begin
    syn = '0;
    for (int i = 1; i < CODE_W; i++)
      if (code_in[i]) syn ^= SYN_W'(i);
    par        = ^code_in;
    repaired   = code_in;
    single_err = 1'b0;
    double_err = 1'b0;
    if (par) begin
      if (int'(syn) < CODE_W) begin
        repaired[syn] = ~code_in[syn];
        single_err    = 1'b1;
      end else begin
        double_err = 1'b1;
      end
    end else if (syn != '0) begin
      double_err = 1'b1;
    end
    raw_data   = code_data(code_in);
    fixed_data = code_data(repaired);
  end

  // R11
  single_double_excl_chk: assert final (!(single_err && double_err));
endmodule

// File: rtl/lane_merge.sv
module lane_merge
  import rmw_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_word,
  input  logic [LANES-1:0]  lane_en,
  output logic [DATA_W-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[8*g +: 8] = lane_en[g] ? new_word[8*g +: 8] : old_word[8*g +: 8];
  end
endmodule

// File: rtl/rmw_ecc_ctrl.sv
module rmw_ecc_ctrl
  import rmw_ecc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ecc_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              corr_err,
  output logic              ecc_alarm,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [CODE_W-1:0] mem_wdata,
  input  logic [CODE_W-1:0] mem_rdata
);
  rmw_state_t        state;
  logic              op_write;
  logic [LANES-1:0]  op_be;
  logic [DATA_W-1:0] op_wdata;

  logic [DATA_W-1:0] dec_raw, dec_fixed, old_word, merged, enc_in;
  logic              dec_single, dec_double, flag_ce, flag_ue;
  logic [CODE_W-1:0] enc_out;
  logic              accept, full_wr;

  secded_dec u_dec (
    .code_in   (mem_rdata),
    .raw_data  (dec_raw),
    .fixed_data(dec_fixed),
    .single_err(dec_single),
    .double_err(dec_double)
  );

  assign flag_ce  = ecc_en && dec_single;
  assign flag_ue  = ecc_en && dec_double;
  assign old_word = ecc_en ? dec_fixed : dec_raw;

  lane_merge u_merge (
    .old_word(old_word),
    .new_word(op_wdata),
    .lane_en (op_be),
    .merged  (merged)
  );

  // one encoder shared by the direct write and the write-back
  assign enc_in = (state == ST_MERGE) ? merged : req_wdata;

  secded_enc u_enc (
    .data_in (enc_in),
    .code_out(enc_out)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign full_wr   = req_write && (&req_be);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_write  <= 1'b0;
      op_be     <= '0;
      op_wdata  <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      corr_err  <= 1'b0;
      ecc_alarm <= 1'b0;
    end else begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      rsp_valid <= 1'b0;
      corr_err  <= 1'b0;
      ecc_alarm <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_write <= req_write;
            op_be    <= req_be;
            op_wdata <= req_wdata;
            mem_en   <= 1'b1;
            mem_addr <= req_addr;
            if (full_wr) begin
              mem_we    <= 1'b1;
              mem_wdata <= enc_out;
            end else begin
              state <= ST_READ;
            end
          end
        end
        ST_READ: state <= ST_MERGE;
        ST_MERGE: begin
          corr_err  <= flag_ce;
          ecc_alarm <= flag_ue;
          if (op_write) begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_wdata <= enc_out;
            state     <= ST_WRITE;
          end else begin
            rsp_valid <= 1'b1;
            rsp_rdata <= old_word;
            rsp_err   <= flag_ue;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  full_write_direct_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && full_wr) |=> (mem_en && mem_we && req_ready));

  // R3
  narrow_reads_first_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !full_wr) |=> (mem_en && !mem_we && !req_ready));

  // R3
  narrow_writes_back_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write && !full_wr) |-> ##3 (mem_en && mem_we));

  // R4
  read_rsp_due_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_write) |-> ##3 rsp_valid);

  // R6
  err_rsp_alarm_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> ecc_alarm);

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ecc_en) |-> (!corr_err && !ecc_alarm && !(rsp_valid && rsp_err)));

  // R11
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({corr_err, ecc_alarm}));
endmodule

// File: tb/test_rmw_ecc_ctrl.sv
module test_rmw_ecc_ctrl;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NW    = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ecc_en = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]  req_be = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err, corr_err, ecc_alarm;
  logic [63:0] rsp_rdata;
  logic        mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [71:0] mem_wdata;
  logic [71:0] mem_rdata = '0;

  logic [71:0] mem [DEPTH];
  logic        fill_go = 1'b0, inj_go = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [71:0] inj_mask = '0;

  logic [63:0] expw [NW];
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  rmw_ecc_ctrl #(.AW(AW)) i_rmw_ecc_ctrl (
    .clk(clk), .rst(rst), .ecc_en(ecc_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .corr_err(corr_err), .ecc_alarm(ecc_alarm),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [71:0] rnd72();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[71:0];
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [63:0] lane_mix(input logic [63:0] o, input logic [63:0] n,
                                           input logic [7:0] be);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = be[k] ? n[8*k +: 8] : o[8*k +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    if (fill_go) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= rnd72();
    end else if (inj_go) begin
      mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    end else if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic flip(input int a, input logic [71:0] m);
    @(negedge clk);
    inj_addr = AW'(a); inj_mask = m; inj_go = 1'b1;
    @(negedge clk);
    inj_go = 1'b0;
  endtask

  // returns at the first falling edge after acceptance
  task automatic issue(input logic w, input int a, input logic [7:0] be, input logic [63:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input int a, input logic [63:0] exp, input logic e_ce,
                         input logic e_ue, input logic cmp, input string req);
    issue(1'b0, a, 8'h00, 64'd0);
    @(negedge clk);
    chk(!rsp_valid, "R4 early", {63'd0, rsp_valid}, 64'd0);
    @(negedge clk);
    chk(rsp_valid, "R4 valid", {63'd0, rsp_valid}, 64'd1);
    if (cmp) chk(rsp_rdata == exp, req, rsp_rdata, exp);
    chk(corr_err == e_ce && ecc_alarm == e_ue && rsp_err == e_ue, req,
        {61'd0, corr_err, ecc_alarm, rsp_err}, {61'd0, e_ce, e_ue, e_ue});
  endtask

  task automatic do_write(input int a, input logic [7:0] be, input logic [63:0] d,
                          input logic e_ce, input logic e_ue, input string req);
    issue(1'b1, a, be, d);
    if (be == 8'hFF) begin
      chk(req_ready && mem_en && mem_we, "R2 direct", {61'd0, req_ready, mem_en, mem_we}, 64'd7);
    end else begin
      chk(!req_ready && mem_en && !mem_we, "R3 read phase",
          {61'd0, req_ready, mem_en, mem_we}, 64'd2);
      @(negedge clk);
      chk(!req_ready, "R3 stall", {63'd0, req_ready}, 64'd0);
      @(negedge clk);
      chk(!req_ready && mem_en && mem_we && !rsp_valid, "R3 write-back",
          {60'd0, req_ready, mem_en, mem_we, rsp_valid}, 64'd6);
      chk(corr_err == e_ce && ecc_alarm == e_ue, req,
          {62'd0, corr_err, ecc_alarm}, {62'd0, e_ce, e_ue});
      @(negedge clk);
      chk(req_ready, "R3 ready back", {63'd0, req_ready}, 64'd1);
    end
    expw[a] = lane_mix(expw[a], d, be);
  endtask

  function automatic logic [7:0] rnd_be();
    int n, off;
    n   = 1 << ($urandom() % 4);
    off = (int'($urandom() % 32'(8 / n))) * n;
    return 8'(((1 << n) - 1) << off);
  endfunction

  function automatic logic [71:0] two_bits();
    int b1, b2;
    b1 = int'($urandom() % 72);
    b2 = (b1 + 1 + int'($urandom() % 71)) % 72;
    return (72'd1 << b1) | (72'd1 << b2);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready && !rsp_valid && !corr_err && !ecc_alarm && !mem_en, "R1 in reset",
        {59'd0, req_ready, rsp_valid, corr_err, ecc_alarm, mem_en}, 64'h10);
    fill_go = 1'b1;
    @(negedge clk);
    fill_go = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !corr_err && !ecc_alarm && !mem_en, "R1 after reset",
        {59'd0, req_ready, rsp_valid, corr_err, ecc_alarm, mem_en}, 64'h10);

    // R9: initialise garbage rows lane by lane with checking off
    ecc_en = 1'b0;
    for (int a = 0; a < NW; a++) begin
      logic [63:0] d;
      d = rnd64();
      expw[a] = '0;
      for (int b = 0; b < 8; b++) do_write(a, 8'(1 << b), d, 1'b0, 1'b0, "R9 init");
    end
    ecc_en = 1'b1;
    for (int a = 0; a < NW; a++) do_read(a, expw[a], 1'b0, 1'b0, 1'b1, "R9 readback");

    // R2 and R3 directed
    do_write(1, 8'hFF, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, "R2");
    do_read(1, expw[1], 1'b0, 1'b0, 1'b1, "R2 data");
    do_write(1, 8'h01, 64'hFFFF_FFFF_FFFF_FF5A, 1'b0, 1'b0, "R3 byte");
    do_write(1, 8'hC0, 64'hA5C3_0000_0000_0000, 1'b0, 1'b0, "R3 half");
    do_write(1, 8'h0F, 64'h0000_0000_DEAD_BEEF, 1'b0, 1'b0, "R3 word");
    do_read(1, expw[1], 1'b0, 1'b0, 1'b1, "R3 merged data");

    // R5: single flip, corrected on read
    for (int i = 0; i < 6; i++) begin
      flip(2, 72'd1 << (i * 14));
      do_read(2, expw[2], 1'b1, 1'b0, 1'b1, "R5 single");
      do_write(2, 8'hFF, expw[2], 1'b0, 1'b0, "R5 restore");
    end

    // R6: double flip on read
    flip(3, two_bits());
    do_read(3, 64'd0, 1'b0, 1'b1, 1'b0, "R6 double");
    do_write(3, 8'hFF, expw[3], 1'b0, 1'b0, "R6 restore");

    // R7: double flip in merge read phase
    flip(4, two_bits());
    issue(1'b1, 4, 8'h02, 64'h0000_0000_0000_7700);
    @(negedge clk);
    @(negedge clk);
    chk(ecc_alarm && !corr_err, "R7 alarm", {62'd0, ecc_alarm, corr_err}, 64'd2);
    repeat (3) begin
      @(negedge clk);
      chk(!rsp_valid, "R7 no response", {63'd0, rsp_valid}, 64'd0);
    end
    do_write(4, 8'hFF, expw[4], 1'b0, 1'b0, "R7 restore");
    do_read(4, expw[4], 1'b0, 1'b0, 1'b1, "R7 restored");

    // R10: single flip repaired during merge and written back clean
    flip(5, 72'd1 << 37);
    do_write(5, 8'h30, 64'h0000_1234_0000_0000, 1'b1, 1'b0, "R10 merge ce");
    do_read(5, expw[5], 1'b0, 1'b0, 1'b1, "R10 clean");

    // R8: checking off, corrupted rows raise nothing
    ecc_en = 1'b0;
    flip(6, two_bits());
    do_read(6, 64'd0, 1'b0, 1'b0, 1'b0, "R8 quiet read");
    flip(7, 72'd1 << 5);
    do_write(7, 8'h80, 64'h1100_0000_0000_0000, 1'b0, 1'b0, "R8 quiet merge");
    do_write(6, 8'hFF, expw[6], 1'b0, 1'b0, "R8 restore");
    do_write(7, 8'hFF, expw[7], 1'b0, 1'b0, "R8 restore");
    ecc_en = 1'b1;

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      int a;
      a = int'($urandom() % NW);
      if ($urandom() % 2 == 0) do_read(a, expw[a], 1'b0, 1'b0, 1'b1, "R4 random read");
      else                     do_write(a, rnd_be(), rnd64(), 1'b0, 1'b0, "R3 random write");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule